// File: doc/BRIEF.md
# Bridge Type-1 Configuration Header Registers

This block holds the configuration header that a PCI-to-PCI bridge presents to software. It is accessed through one plain dword port: a dword index selects a register, a write strobe stores the write data, and the read data always shows the register the index selects. Stored fields go into and come out of the dword layout of a Type 1 header. Writes are always whole dwords.

The identity fields come in on input pins and cannot be written: device ID, vendor ID and revision. The class code, header type and cache line size are constants. The block stores the following:

- the command register;
- two BARs;
- the bus-number bytes;
- the I/O base/limit pair and its upper-16 extension;
- the memory base/limit pair.

An I/O base/limit write always stores the 32-bit addressing-type code in the low nibble of both bytes. A write that flips the I/O enable bit or the memory enable bit of the command register raises a one-cycle pulse. The logic that builds the address windows uses these pulses to rebuild them.

Top module: `p2p_hdr_regs`

## Requirements
- R1: At index 0 the read data is {dev_id, ven_id}. At index 2 it is {16'h0604, 8'h00, rev_id}: bridge class, programming interface zero, revision.
- R2: At index 3 the read data is always 32'h0001_0010: BIST 0, header type 0x01, latency timer 0, cache line size 0x10. Writes to index 3 change nothing.
- R3: A write to index 1 stores wr_data[15:0] as the command. A read at index 1 returns {16'h0000, command}.
- R4: When a command write changes bit 0 (I/O enable), io_win_upd is high for the one cycle after the write edge. Otherwise io_win_upd stays low.
- R5: When a command write changes bit 1 (memory enable), mem_win_upd is high for the one cycle after the write edge. Otherwise mem_win_upd stays low.
- R6: Indices 4 and 5 (byte offsets 0x10 and 0x14) are two 32-bit BARs. Each reads back exactly what was last written to it.
- R7: Index 6 holds the primary bus in byte 0, secondary bus in byte 1, subordinate bus in byte 2 and secondary latency timer in byte 3. A write updates all four bytes.
- R8: Index 7 reads {16'h0000, io_limit, io_base}, with a secondary status of zero. A write stores wr_data[7:0]|8'h01 into io_base and wr_data[15:8]|8'h01 into io_limit.
- R9: Index 8 holds memory base in [15:0] and memory limit in [31:16]. Index 12 (offset 0x30) holds I/O base upper in [15:0] and I/O limit upper in [31:16]. Both store the full write data.
- R10: After reset, io_base and io_limit are 8'h01, so index 7 reads 32'h0000_0101. All other writable fields read zero, and neither pulse is high.
- R11: Indices 9, 10, 11 and 13 and above read zero. Writes to them, and to indices 0 and 2, change no readable field and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_idx | input | IDX_W (6) | Dword index (byte offset / 4) for read and write |
| wr_en | input | 1 | Write strobe, stores wr_data at cfg_idx |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for cfg_idx (combinational) |
| dev_id | input | 16 | Device ID, read-only |
| ven_id | input | 16 | Vendor ID, read-only |
| rev_id | input | 8 | Revision, read-only |
| io_win_upd | output | 1 | One-cycle pulse when command bit 0 toggled |
| mem_win_upd | output | 1 | One-cycle pulse when command bit 1 toggled |

## Verification
The bench goes after the forced type code on I/O base/limit writes. Writing 0xF0F0 must read back 0xF1F1, so a design that stores raw bytes returns 0xF0F0. It writes the command register with the enable bits unchanged, then toggled one at a time, then both together. A design that pulses on every command write, or that compares the wrong bit, shows a pulse in the wrong cycle or on the wrong output. It writes to read-only and unused indices and then re-reads neighbouring registers, which catches a decoder that aliases or drops index bits.

// File: rtl/p2p_hdr_regs.sv
module p2p_hdr_regs #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic [15:0]      dev_id,
  input  logic [15:0]      ven_id,
  input  logic [7:0]       rev_id,
  output logic             io_win_upd,
  output logic             mem_win_upd
);
  localparam int NBAR = 2;
  localparam logic [IDX_W-1:0] I_ID   = IDX_W'(0);
  localparam logic [IDX_W-1:0] I_CMD  = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_CLS  = IDX_W'(2);
  localparam logic [IDX_W-1:0] I_HDR  = IDX_W'(3);
  localparam logic [IDX_W-1:0] I_BAR0 = IDX_W'(4);
  localparam logic [IDX_W-1:0] I_BUS  = IDX_W'(6);
  localparam logic [IDX_W-1:0] I_IO   = IDX_W'(7);
  localparam logic [IDX_W-1:0] I_MEM  = IDX_W'(8);
  localparam logic [IDX_W-1:0] I_IOUP = IDX_W'(12);
  localparam logic [7:0]  IO32     = 8'h01;
  localparam logic [15:0] CLS_P2P  = 16'h0604;
  localparam logic [7:0]  HDR_TYP1 = 8'h01;
  localparam logic [7:0]  CLINE    = 8'h10;

  logic [15:0] cmd_q;
  logic [31:0] bar_q [NBAR];
  logic [31:0] bus_q, mem_q, ioup_q;
  logic [7:0]  io_base_q, io_lim_q;

  wire wr_cmd = wr_en && cfg_idx == I_CMD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      bus_q       <= '0;
      mem_q       <= '0;
      ioup_q      <= '0;
      io_base_q   <= IO32;
      io_lim_q    <= IO32;
      io_win_upd  <= 1'b0;
      mem_win_upd <= 1'b0;
    end else begin
      io_win_upd  <= wr_cmd && (wr_data[0] != cmd_q[0]);
      mem_win_upd <= wr_cmd && (wr_data[1] != cmd_q[1]);
      if (wr_en) begin
        case (cfg_idx)
          I_CMD:  cmd_q  <= wr_data[15:0];
          I_BUS:  bus_q  <= wr_data;
          I_MEM:  mem_q  <= wr_data;
          I_IOUP: ioup_q <= wr_data;
          I_IO: begin
            io_base_q <= wr_data[7:0]  | IO32;
            io_lim_q  <= wr_data[15:8] | IO32;
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar b = 0; b < NBAR; b++) begin : g_bar
    always_ff @(posedge clk) begin
      if (!rst_n)
        bar_q[b] <= '0;
      else if (wr_en && cfg_idx == I_BAR0 + IDX_W'(b))
        bar_q[b] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    case (cfg_idx)
      I_ID:   rd_data = {dev_id, ven_id};
      I_CMD:  rd_data = {16'h0000, cmd_q};
      I_CLS:  rd_data = {CLS_P2P, 8'h00, rev_id};
      I_HDR:  rd_data = {8'h00, HDR_TYP1, 8'h00, CLINE};
      I_BUS:  rd_data = bus_q;
      I_IO:   rd_data = {16'h0000, io_lim_q, io_base_q};
      I_MEM:  rd_data = mem_q;
      I_IOUP: rd_data = ioup_q;
      default: begin
        for (int b = 0; b < NBAR; b++)
          if (cfg_idx == I_BAR0 + IDX_W'(b)) rd_data = bar_q[b];
      end
    endcase
  end
endmodule

// File: rtl/p2p_hdr_regs_chk.sv
module p2p_hdr_regs_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] cfg_idx,
  input logic             wr_en,
  input logic [31:0]      rd_data,
  input logic [15:0]      dev_id,
  input logic [15:0]      ven_id,
  input logic             io_win_upd,
  input logic             mem_win_upd
);
  assert_id_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idx == IDX_W'(0)) |-> rd_data == {dev_id, ven_id});

  assert_hdr_const_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idx == IDX_W'(3)) |-> rd_data == 32'h0001_0010);

  assert_io_pulse_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    io_win_upd |-> $past(wr_en && cfg_idx == IDX_W'(1)));

  assert_mem_pulse_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_win_upd |-> $past(wr_en && cfg_idx == IDX_W'(1)));

  assert_io_type_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idx == IDX_W'(7)) |-> (rd_data[0] && rd_data[8] && rd_data[31:16] == 16'h0000));

  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idx > IDX_W'(12) || (cfg_idx >= IDX_W'(9) && cfg_idx <= IDX_W'(11))) |-> rd_data == 32'h0);
endmodule

bind p2p_hdr_regs p2p_hdr_regs_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_idx(cfg_idx), .wr_en(wr_en), .rd_data(rd_data),
  .dev_id(dev_id), .ven_id(ven_id), .io_win_upd(io_win_upd), .mem_win_upd(mem_win_upd)
);

// File: tb/p2p_hdr_regs_tb_top.sv
module p2p_hdr_regs_tb_top;
  localparam int IDX_W = 6;
  localparam logic [15:0] DEV = 16'h7846;
  localparam logic [15:0] VEN = 16'h1AB5;
  localparam logic [7:0]  REV = 8'h3C;
  localparam int NV = 13;
  // entry: {req[3:0], idx[5:0], wdata[31:0], expected readback[31:0]}
  localparam logic [73:0] VEC [NV] = '{
    {4'd3,  6'd1,  32'hFFFF_0007, 32'h0000_0007},  // R3 upper half dropped
    {4'd6,  6'd4,  32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R6 BAR0
    {4'd6,  6'd5,  32'h1234_5678, 32'h1234_5678},  // R6 BAR1
    {4'd7,  6'd6,  32'h4033_2211, 32'h4033_2211},  // R7 bus bytes
    {4'd8,  6'd7,  32'h0000_F0F0, 32'h0000_F1F1},  // R8 type code forced
    {4'd8,  6'd7,  32'hFFFF_2010, 32'h0000_2111},  // R8 status not writable
    {4'd9,  6'd8,  32'hFFF0_1230, 32'hFFF0_1230},  // R9 memory window
    {4'd9,  6'd12, 32'hABCD_0102, 32'hABCD_0102},  // R9 I/O upper
    {4'd11, 6'd0,  32'hFFFF_FFFF, {DEV, VEN}},     // R11 id read-only
    {4'd2,  6'd3,  32'hFFFF_FFFF, 32'h0001_0010},  // R2 constants
    {4'd1,  6'd2,  32'h0000_0000, {16'h0604, 8'h00, REV}}, // R1
    {4'd11, 6'd9,  32'h5555_5555, 32'h0000_0000},  // R11 unused
    {4'd11, 6'd63, 32'h0000_0001, 32'h0000_0000}   // R11 top index
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic io_win_upd, mem_win_upd;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  p2p_hdr_regs #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_idx(cfg_idx), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .dev_id(DEV), .ven_id(VEN), .rev_id(REV),
    .io_win_upd(io_win_upd), .mem_win_upd(mem_win_upd));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [IDX_W-1:0] i, input logic [31:0] d);
    @(negedge clk);
    cfg_idx = i; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd_chk(input string req, input logic [IDX_W-1:0] i, input logic [31:0] exp);
    cfg_idx = i;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic pulse_chk(input string req, input logic io_e, input logic mem_e);
    check(req, {30'b0, mem_win_upd, io_win_upd}, {30'b0, mem_e, io_e});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset values
    rd_chk("R10 cmd", 1, 0);
    rd_chk("R10 bar0", 4, 0);
    rd_chk("R10 bar1", 5, 0);
    rd_chk("R10 bus", 6, 0);
    rd_chk("R10 io", 7, 32'h0000_0101);
    rd_chk("R10 mem", 8, 0);
    rd_chk("R10 ioup", 12, 0);
    pulse_chk("R10 pulses", 0, 0);

    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][69:64], VEC[k][63:32]);
      n_chk++;
      if (rd_data !== VEC[k][31:0]) begin
        n_bad++;
        $display("FAIL R%0d vec %0d actual=%h expected=%h", VEC[k][73:70], k, rd_data, VEC[k][31:0]);
      end
    end

    // R11 unused writes left other fields alone
    rd_chk("R11 bar0 kept", 4, 32'hDEAD_BEEF);
    rd_chk("R11 bar1 kept", 5, 32'h1234_5678);
    rd_chk("R11 cmd kept", 1, 32'h0000_0007);
    rd_chk("R11 ioup kept", 12, 32'hABCD_0102);
    pulse_chk("R11 no pulse", 0, 0);

    // R4 / R5 pulse behaviour; command currently 0x0007
    wr(1, 32'h0000_0007);
    pulse_chk("R4 R5 no change", 0, 0);
    wr(1, 32'h0000_0006);
    pulse_chk("R4 io toggle", 1, 0);
    @(negedge clk); #1;
    pulse_chk("R4 one cycle", 0, 0);
    wr(1, 32'h0000_0004);
    pulse_chk("R5 mem toggle", 0, 1);
    wr(1, 32'h0000_0007);
    pulse_chk("R4 R5 both", 1, 1);
    wr(1, 32'h0000_0007);
    pulse_chk("R4 R5 unchanged again", 0, 0);
    wr(1, 32'h0000_FFFC);
    pulse_chk("R4 R5 both off", 1, 1);
    rd_chk("R3 cmd 16 bits", 1, 32'h0000_FFFC);
    wr(7, 32'h0000_0000);
    rd_chk("R8 zero write", 7, 32'h0000_0101);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule